// File: doc/BRIEF.md
# Octet Slip Buffer with Selectable Time-Slot Output

This block takes complete octets that arrive at a rate set by a far-end transmitter and plays each one out as a short serial burst inside a read time slot. The time slot is timed by a local clock. Line decoding and clock recovery happen upstream. An upstream stage hands over one finished octet per `octetValid` pulse, in the local clock domain. Two time-slot start strobes are offered, and a select input chooses which one opens a slot. When the slot opens, the block sends one stored octet serially, most significant bit first, one bit per clock. Between slots the serial line rests high.

The two rates are not locked to each other, so a two-octet buffer sits between the writer and the reader. If the writer gets ahead and the buffer is full, the incoming octet is thrown away whole. If the reader gets ahead and the buffer is empty, the octet sent last is sent again. In both cases bit grouping is kept. Each slip raises a one-cycle flag that says which kind of slip it was.

Top module: `octet_slip_buffer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `serOut` is 1, `outValid` is 0, and both slip flags are 0.
- R2: With `tsSel` = 1, only `tsA` can open a slot, and `tsB` is ignored. With `tsSel` = 0, only `tsB` can open a slot, and `tsA` is ignored.
- R3: A slot opens on a clock edge that samples the selected strobe high. From the next cycle, `serOut` carries the WIDTH bits of one octet, most significant bit first, one per cycle. `outValid` is 1 for exactly those cycles.
- R4: Whenever `outValid` is 0, `serOut` is 1.
- R5: A selected strobe that is sampled while a burst still has bits left is ignored. A strobe sampled on the edge that sends the last bit is also ignored. A strobe sampled on the edge right after the last bit does open a new slot.
- R6: The buffer holds up to DEPTH (2) octets and gives them out oldest first, one per slot.
- R7: If an `octetValid` pulse arrives while the buffer is full and no slot opens on the same edge, the incoming octet is dropped. `slipDelete` then pulses for one cycle, aligned with the cycle after that edge.
- R8: If a slot opens while the buffer is empty, the last octet that was sent is sent again. After reset this octet is 8'hFF. `slipRepeat` pulses during the first bit cycle of that burst.
- R9: On an edge where a slot opens and an octet arrives together, the read happens first. With a full buffer, the new octet is stored and no slip occurs. With an empty buffer, a repeat occurs and the new octet is stored for the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bit clock |
| rst | input | 1 | Asynchronous active-high reset |
| octetValid | input | 1 | One-cycle pulse: `octetIn` holds a finished octet |
| octetIn | input | WIDTH | Received octet |
| tsA | input | 1 | First time-slot start strobe |
| tsB | input | 1 | Second time-slot start strobe |
| tsSel | input | 1 | 1 selects `tsA`, 0 selects `tsB` |
| serOut | output | 1 | Registered serial output; idles at 1 |
| outValid | output | 1 | High while `serOut` carries burst bits |
| slipDelete | output | 1 | One-cycle flag: an incoming octet was dropped |
| slipRepeat | output | 1 | One-cycle flag: the previous octet is being resent |

## Verification
The bench first steps through directed cases. These are:
- a slot opened on an empty buffer straight after reset;
- sparse writes followed by sparse slots;
- each strobe tried under both select settings;
- strobes placed inside a burst, on its last bit and just after it;
- three writes with no read;
- arrivals on the same edge as a slot opening, with the buffer full and with it empty.

It then runs two long streams. In the first, writes come faster than slots. In the second, writes come slower than slots. These streams show that periodic deletes and repeats keep whole octets in the right order. A behavioural queue model predicts every output on every cycle. So a wrong bit order, an off-by-one burst length, a strobe taken from the wrong source, or a slip raised on the wrong edge each shows up as a separate mismatch.

// File: rtl/osb_pkg.sv
package osb_pkg;
  typedef struct packed {
    logic load;   // open a burst this edge
    logic pop;    // take oldest buffered octet (else resend last)
    logic push;   // store the incoming octet
    logic shift;  // advance the running burst
  } osbStrobes_t;
endpackage

// File: rtl/osb_ctrl.sv
module osb_ctrl
  import osb_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        octetValid,
  input  logic        tsA,
  input  logic        tsB,
  input  logic        tsSel,
  output osbStrobes_t strb,
  output logic        outValid,
  output logic        slipDelete,
  output logic        slipRepeat
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = (WIDTH > 2) ? $clog2(WIDTH) : 1;

  logic [CW-1:0] fill;
  logic [BW-1:0] bitsLeft;
  logic          slotStrobe;
  logic          slotStart;
  logic          burstBusy;

  assign slotStrobe = tsSel ? tsA : tsB;
  assign burstBusy  = (bitsLeft != '0);
  assign slotStart  = slotStrobe && !burstBusy;

  always_comb begin
    strb.load  = slotStart;
    strb.pop   = slotStart && (fill != '0);
    strb.push  = octetValid && ((fill != CW'(DEPTH)) || strb.pop);
    strb.shift = burstBusy;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      fill       <= '0;
      bitsLeft   <= '0;
      outValid   <= 1'b0;
      slipDelete <= 1'b0;
      slipRepeat <= 1'b0;
    end else begin
      fill       <= fill + CW'(strb.push) - CW'(strb.pop);
      if (slotStart)      bitsLeft <= BW'(WIDTH - 1);
      else if (burstBusy) bitsLeft <= bitsLeft - 1'b1;
      outValid   <= slotStart || burstBusy;
      slipDelete <= octetValid && !strb.push;
      slipRepeat <= slotStart && !strb.pop;
    end
  end
endmodule

// File: rtl/osb_datapath.sv
module osb_datapath
  import osb_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  osbStrobes_t      strb,
  input  logic [WIDTH-1:0] octetIn,
  output logic             serOut
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    rdPtr, wrPtr;
  logic [WIDTH-1:0] lastOctet;
  logic [WIDTH-1:0] shiftReg;
  logic [WIDTH-1:0] loadData;

  function automatic logic [PW-1:0] stepPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign loadData = strb.pop ? store[rdPtr] : lastOctet;

  always_ff @(posedge clk) begin
    if (strb.push) store[wrPtr] <= octetIn;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      lastOctet <= '1;
      shiftReg  <= '1;
      serOut    <= 1'b1;
    end else begin
      if (strb.push) wrPtr <= stepPtr(wrPtr);
      if (strb.pop)  rdPtr <= stepPtr(rdPtr);
      if (strb.load) begin
        lastOctet <= loadData;
        serOut    <= loadData[WIDTH-1];
        shiftReg  <= {loadData[WIDTH-2:0], 1'b1};
      end else if (strb.shift) begin
        serOut    <= shiftReg[WIDTH-1];
        shiftReg  <= {shiftReg[WIDTH-2:0], 1'b1};
      end else begin
        serOut    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/octet_slip_buffer.sv
module octet_slip_buffer
  import osb_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             octetValid,
  input  logic [WIDTH-1:0] octetIn,
  input  logic             tsA,
  input  logic             tsB,
  input  logic             tsSel,
  output logic             serOut,
  output logic             outValid,
  output logic             slipDelete,
  output logic             slipRepeat
);
  osbStrobes_t strb;

  osb_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .octetValid(octetValid),
    .tsA(tsA), .tsB(tsB), .tsSel(tsSel), .strb(strb),
    .outValid(outValid), .slipDelete(slipDelete), .slipRepeat(slipRepeat)
  );

  osb_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .octetIn(octetIn), .serOut(serOut)
  );
endmodule

// File: rtl/osb_checker.sv
module osb_checker #(
  parameter int WIDTH = 8
) (
  input logic clk,
  input logic rst,
  input logic octetValid,
  input logic serOut,
  input logic outValid,
  input logic slipDelete,
  input logic slipRepeat
);
  localparam int RW = $clog2(WIDTH + 1);
  logic [RW-1:0] runPos;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) runPos <= '0;
    else if (outValid) runPos <= (runPos == RW'(WIDTH - 1)) ? '0 : runPos + 1'b1;
  end

  assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> serOut);

  assert_burst_whole_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(outValid) |-> (runPos == '0));

  assert_slip_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(slipDelete && slipRepeat));

  assert_delete_needs_octet_R7: assert property (@(posedge clk) disable iff (rst)
    slipDelete |-> $past(octetValid));

  assert_repeat_in_burst_R8: assert property (@(posedge clk) disable iff (rst)
    slipRepeat |-> outValid);
endmodule

bind octet_slip_buffer osb_checker #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .octetValid(octetValid), .serOut(serOut),
  .outValid(outValid), .slipDelete(slipDelete), .slipRepeat(slipRepeat)
);

// File: tb/octet_slip_buffer_tb_top.sv
`timescale 1ns/1ps
module octet_slip_buffer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic octetValid = 1'b0;
  logic [7:0] octetIn = 8'h00;
  logic tsA = 1'b0, tsB = 1'b0, tsSel = 1'b1;
  logic serOut, outValid, slipDelete, slipRepeat;

  always #2.5 clk = ~clk;

  octet_slip_buffer #(.WIDTH(8), .DEPTH(2)) dut_i (
    .clk(clk), .rst(rst), .octetValid(octetValid), .octetIn(octetIn),
    .tsA(tsA), .tsB(tsB), .tsSel(tsSel), .serOut(serOut),
    .outValid(outValid), .slipDelete(slipDelete), .slipRepeat(slipRepeat)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  string phase = "R1 reset";

  // behavioural reference model
  logic [7:0] q[$];
  logic [7:0] lastSent = 8'hFF;
  logic [7:0] bitsM = 8'hFF;
  int remM = 0;
  logic eOut = 1'b1, eVal = 1'b0, eDel = 1'b0, eRep = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); lastSent = 8'hFF; remM = 0;
      eOut = 1'b1; eVal = 1'b0; eDel = 1'b0; eRep = 1'b0;
    end else begin
      logic sel;
      logic [7:0] d;
      sel = tsSel ? tsA : tsB;
      eRep = 1'b0; eDel = 1'b0;
      if (sel && remM == 0) begin
        if (q.size() > 0) d = q.pop_front();
        else begin d = lastSent; eRep = 1'b1; end
        lastSent = d;
        eOut = d[7]; bitsM = d << 1; remM = 7; eVal = 1'b1;
      end else if (remM > 0) begin
        eOut = bitsM[7]; bitsM = bitsM << 1; remM--; eVal = 1'b1;
      end else begin
        eOut = 1'b1; eVal = 1'b0;
      end
      if (octetValid) begin
        if (q.size() < 2) q.push_back(octetIn);
        else eDel = 1'b1;
      end
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL [%s] %s at %0t: actual %b expected %b", phase, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("serOut (R3 R4 R6)", serOut, eOut);
      chk("outValid (R3 R5)", outValid, eVal);
      chk("slipDelete (R7)", slipDelete, eDel);
      chk("slipRepeat (R8)", slipRepeat, eRep);
    end
  end

  task automatic cyc(input logic v, input logic [7:0] d, input logic a, input logic b);
    @(negedge clk);
    octetValid = v; octetIn = d; tsA = a; tsB = b;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL [watchdog] run did not complete: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    logic [7:0] lcg;
    lcg = 8'h5B;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(3);

    phase = "R8 underrun after reset";
    tsSel = 1'b1;
    cyc(1'b0, 8'h00, 1'b1, 1'b0); idle(12);

    phase = "R3 R6 ordered bursts";
    cyc(1'b1, 8'hA5, 1'b0, 1'b0); idle(3);
    cyc(1'b1, 8'h3C, 1'b0, 1'b0); idle(3);
    cyc(1'b0, 8'h00, 1'b1, 1'b0); idle(10);
    cyc(1'b0, 8'h00, 1'b1, 1'b0); idle(10);

    phase = "R2 strobe select";
    cyc(1'b1, 8'h81, 1'b0, 1'b0);
    cyc(1'b1, 8'h7E, 1'b0, 1'b0);
    tsSel = 1'b0;
    cyc(1'b0, 8'h00, 1'b1, 1'b0); idle(10);
    cyc(1'b0, 8'h00, 1'b0, 1'b1); idle(10);
    tsSel = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b1); idle(10);
    cyc(1'b0, 8'h00, 1'b1, 1'b0); idle(10);

    phase = "R5 strobes during burst";
    cyc(1'b1, 8'hC3, 1'b0, 1'b0);
    cyc(1'b1, 8'h18, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    idle(2); cyc(1'b0, 8'h00, 1'b1, 1'b0);
    idle(3); cyc(1'b0, 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    idle(12);

    phase = "R7 overrun delete";
    cyc(1'b1, 8'h11, 1'b0, 1'b0);
    cyc(1'b1, 8'h22, 1'b0, 1'b0);
    cyc(1'b1, 8'h33, 1'b0, 1'b0);
    idle(2);
    cyc(1'b0, 8'h00, 1'b1, 1'b0); idle(9);

    phase = "R9 read and write together";
    cyc(1'b1, 8'h44, 1'b0, 1'b0); idle(1);
    cyc(1'b1, 8'h55, 1'b1, 1'b0); idle(9);
    cyc(1'b0, 8'h00, 1'b1, 1'b0); idle(9);
    cyc(1'b0, 8'h00, 1'b1, 1'b0); idle(9);
    cyc(1'b1, 8'h96, 1'b1, 1'b0); idle(9);
    cyc(1'b0, 8'h00, 1'b1, 1'b0); idle(12);

    phase = "R7 R6 fast writer stream";
    for (int i = 0; i < 900; i++) begin
      lcg = lcg * 8'd37 + 8'd11;
      cyc(i % 9 == 0, lcg, i % 10 == 0, 1'b0);
    end
    idle(12);

    phase = "R8 R2 slow writer stream";
    tsSel = 1'b0;
    for (int i = 0; i < 900; i++) begin
      lcg = lcg * 8'd37 + 8'd11;
      cyc(i % 11 == 0, lcg, i % 3 == 0, i % 10 == 0);
    end
    idle(12);

    phase = "R1 reset again";
    @(negedge clk); rst = 1'b1;
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(2);

    finishRun();
  end
endmodule